// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block decides whether a protected-mode segment register load, a far control transfer or an I/O-sensitive instruction may proceed under a four-ring privilege model. Ring 0 is the most trusted ring and ring 3 the least. The caller presents the current ring, the 16-bit selector used by the request, and the fields of the already-fetched target descriptor: its privilege level, whether it is code, and whether it is conforming. For gated calls the caller also presents the gate's privilege level and whether the gate is a call gate. For I/O-sensitive instructions it presents the I/O privilege level. The block answers with allow or fault, the ring the processor runs at afterwards, and the effective privilege level. A fault carries the general-protection vector and the offending selector.

The decision is purely combinational. A parameter can add one register stage on the result, so the check can sit on a pipeline boundary without changing its meaning. Descriptor fetch, stack switching and parameter copying belong to the surrounding logic.

Top module: `privCheckUnit`

## Requirements
- R1: The selector is decoded as RPL in bits 1:0, table indicator in bit 2 (0 = global, 1 = local) and index in bits 15:3. The selector is null only when both the index and the table indicator are zero; a local-table selector with index 0 is not null.
- R2: effPl equals the numerically larger of the selector's RPL and curPl, for every request kind.
- R3: A data-segment load (reqKind 0) is allowed when tgtDpl is numerically at least max(curPl, RPL), and is always allowed with a null selector. newPl stays curPl.
- R4: A direct far transfer (reqKind 1) to a non-conforming code target is allowed only when tgtDpl equals curPl. newPl stays curPl.
- R5: A direct far transfer to a conforming code target is allowed when tgtDpl is at most curPl. newPl stays curPl.
- R6: A gated call (reqKind 2) is allowed when all four of these hold: gateDpl ≥ curPl, gateDpl ≥ RPL, gateDpl ≥ tgtDpl, and tgtDpl ≤ curPl. On success newPl is tgtDpl for a non-conforming target and curPl for a conforming one.
- R7: An I/O-sensitive request (reqKind 3) is allowed only when curPl ≤ ioPl. Selector and descriptor inputs have no effect on it, and faultSel stays 0.
- R8: A direct transfer or gated call through a null selector always faults.
- R9: On a fault, faultCode is 13 and faultSel carries the selector (0 for reqKind 3), and newPl is curPl. On an allow, faultCode and faultSel are 0. allow and fault are never both 1.
- R10: A type mismatch faults with code 13. This covers a direct transfer whose target is not code, and a gated call whose gate is not a call gate or whose target is not code.
- R11: With REG_OUT=1, every result appears one clock after the request is sampled, and rspValid follows reqValid with that one-cycle delay. Reset clears rspValid, allow and fault. With REG_OUT=0, results follow the inputs in the same cycle, and allow and fault are 0 while reqValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | 0 data load, 1 direct far transfer, 2 gated call, 3 I/O-sensitive |
| curPl | input | 2 | Current privilege ring |
| selector | input | 16 | Selector used by the request (gate selector for reqKind 2) |
| tgtDpl | input | 2 | Target descriptor privilege level |
| tgtIsCode | input | 1 | Target descriptor is a code segment |
| tgtConforming | input | 1 | Target code segment is conforming |
| gateDpl | input | 2 | Gate descriptor privilege level |
| gateIsCall | input | 1 | Gate descriptor is a call gate |
| ioPl | input | 2 | I/O privilege level |
| rspValid | output | 1 | Result valid |
| allow | output | 1 | Request permitted |
| fault | output | 1 | Request refused |
| faultCode | output | 8 | Exception vector on fault, else 0 |
| faultSel | output | 16 | Offending selector on fault, else 0 |
| newPl | output | 2 | Ring after the request |
| effPl | output | 2 | Effective privilege level |

## Verification
The bench instantiates the unit twice. One instance uses the default REG_OUT=1 and the other uses REG_OUT=0, and both are driven from the same stimulus. This exercises the same-cycle decision and the one-cycle registered delivery side by side. The widths stay at their defaults of 16-bit selectors and 2-bit rings, so random stimulus covers all sixteen combinations of ring and descriptor level. Directed cases cover null and local-index-0 selectors, gate type mismatches and conforming targets reached through a gate.

// File: rtl/privChkPkg.sv
package privChkPkg;
  typedef enum logic [1:0] {
    REQ_DATA   = 2'd0,
    REQ_DIRECT = 2'd1,
    REQ_GATE   = 2'd2,
    REQ_IO     = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic doData;
    logic doDirect;
    logic doGate;
    logic doIo;
    logic selNull;
  } ctrlStrb_t;
endpackage

// File: rtl/privChkCtrl.sv
module privChkCtrl
  import privChkPkg::*;
#(
  parameter int SEL_W = 16,
  parameter int PL_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [SEL_W-1:0] selector,
  output ctrlStrb_t        strb,
  output logic [PL_W-1:0]  rpl
);
  localparam int TI_BIT = PL_W;
  localparam int IDX_LO = PL_W + 1;

  logic idxZero;
  reqKind_e kind;

  assign kind    = reqKind_e'(reqKind);
  assign rpl     = selector[PL_W-1:0];
  assign idxZero = (selector[SEL_W-1:IDX_LO] == '0);

  always_comb begin
    strb          = '0;
    strb.selNull  = idxZero && !selector[TI_BIT];
    if (reqValid) begin
      unique case (kind)
        REQ_DATA:   strb.doData   = 1'b1;
        REQ_DIRECT: strb.doDirect = 1'b1;
        REQ_GATE:   strb.doGate   = 1'b1;
        REQ_IO:     strb.doIo     = 1'b1;
        default:    strb          = strb;
      endcase
    end
  end

  // Exactly one operation strobe per valid request, none otherwise (R11)
  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.doData, strb.doDirect, strb.doGate, strb.doIo}) == (reqValid ? 1 : 0));

  // A local-table selector is never flagged null (R1)
  assert_local_not_null_R1: assert property (@(posedge clk) disable iff (!rstN)
    selector[TI_BIT] |-> !strb.selNull);
endmodule

// File: rtl/privChkDatapath.sv
module privChkDatapath
  import privChkPkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int PL_W    = 2,
  parameter int VEC_W   = 8,
  parameter int GP_VEC  = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  ctrlStrb_t        strb,
  input  logic [PL_W-1:0]  rpl,
  input  logic [PL_W-1:0]  curPl,
  input  logic [SEL_W-1:0] selector,
  input  logic [PL_W-1:0]  tgtDpl,
  input  logic             tgtIsCode,
  input  logic             tgtConforming,
  input  logic [PL_W-1:0]  gateDpl,
  input  logic             gateIsCall,
  input  logic [PL_W-1:0]  ioPl,
  output logic             rspValid,
  output logic             allow,
  output logic             fault,
  output logic [VEC_W-1:0] faultCode,
  output logic [SEL_W-1:0] faultSel,
  output logic [PL_W-1:0]  newPl,
  output logic [PL_W-1:0]  effPl
);
  localparam logic [VEC_W-1:0] GP_CODE = VEC_W'(GP_VEC);

  logic [PL_W-1:0]  effC, newPlC;
  logic             dataOk, directOk, gateOk, ioOk, okC, anyReq, allowC, faultC;
  logic             directPrivOk, gatePrivOk;
  logic [VEC_W-1:0] codeC;
  logic [SEL_W-1:0] selC;

  assign effC = (rpl > curPl) ? rpl : curPl;

  always_comb begin
    dataOk       = strb.selNull || (tgtDpl >= effC);
    directPrivOk = tgtConforming ? (tgtDpl <= curPl) : (tgtDpl == curPl);
    directOk     = !strb.selNull && tgtIsCode && directPrivOk;
    gatePrivOk   = (gateDpl >= curPl) && (gateDpl >= rpl) &&
                   (gateDpl >= tgtDpl) && (tgtDpl <= curPl);
    gateOk       = !strb.selNull && gateIsCall && tgtIsCode && gatePrivOk;
    ioOk         = (curPl <= ioPl);
    okC          = (strb.doData && dataOk) || (strb.doDirect && directOk) ||
                   (strb.doGate && gateOk) || (strb.doIo && ioOk);
    anyReq       = strb.doData || strb.doDirect || strb.doGate || strb.doIo;
    allowC       = anyReq && okC;
    faultC       = anyReq && !okC;
    newPlC       = (allowC && strb.doGate && !tgtConforming) ? tgtDpl : curPl;
    codeC        = faultC ? GP_CODE : '0;
    selC         = (faultC && !strb.doIo) ? selector : '0;
  end

  generate
    if (REG_OUT) begin : gRegOut
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rspValid  <= 1'b0;
          allow     <= 1'b0;
          fault     <= 1'b0;
          faultCode <= '0;
          faultSel  <= '0;
          newPl     <= '0;
          effPl     <= '0;
        end else begin
          rspValid  <= reqValid;
          allow     <= allowC;
          fault     <= faultC;
          faultCode <= codeC;
          faultSel  <= selC;
          newPl     <= newPlC;
          effPl     <= effC;
        end
      end

      // One-cycle response timing (R11)
      assert_valid_delay_R11: assert property (@(posedge clk) disable iff (!rstN)
        reqValid |=> rspValid);
      assert_idle_delay_R11: assert property (@(posedge clk) disable iff (!rstN)
        !reqValid |=> (!rspValid && !allow && !fault));
    end else begin : gCombOut
      always_comb begin
        rspValid  = reqValid;
        allow     = allowC;
        fault     = faultC;
        faultCode = codeC;
        faultSel  = selC;
        newPl     = newPlC;
        effPl     = effC;
      end
    end
  endgenerate

  // Effective level is one of the two inputs and no more trusted than either (R2)
  assert_eff_max_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (effC >= curPl && effC >= rpl && (effC == curPl || effC == rpl)));

  // A non-null data load that passes respects both ring and requestor (R3)
  assert_data_rule_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doData && !strb.selNull && allowC) |-> (tgtDpl >= curPl && tgtDpl >= rpl));

  // A gated call never drops to a less trusted ring (R6)
  assert_gate_ring_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doGate && allowC) |-> (newPlC <= curPl));

  // Code transfers through a null selector fault (R8)
  assert_null_xfer_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.doDirect || strb.doGate) && strb.selNull) |-> faultC);

  // Allow and fault exclusive; fault always carries the vector (R9)
  assert_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(allow && fault));
  assert_fault_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (faultCode == GP_CODE));

  // Non-code targets never pass a code transfer (R10)
  assert_type_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.doDirect || strb.doGate) && !tgtIsCode) |-> faultC);
endmodule

// File: rtl/privCheckUnit.sv
module privCheckUnit
  import privChkPkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int PL_W    = 2,
  parameter int VEC_W   = 8,
  parameter int GP_VEC  = 13,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [PL_W-1:0]  curPl,
  input  logic [SEL_W-1:0] selector,
  input  logic [PL_W-1:0]  tgtDpl,
  input  logic             tgtIsCode,
  input  logic             tgtConforming,
  input  logic [PL_W-1:0]  gateDpl,
  input  logic             gateIsCall,
  input  logic [PL_W-1:0]  ioPl,
  output logic             rspValid,
  output logic             allow,
  output logic             fault,
  output logic [VEC_W-1:0] faultCode,
  output logic [SEL_W-1:0] faultSel,
  output logic [PL_W-1:0]  newPl,
  output logic [PL_W-1:0]  effPl
);
  ctrlStrb_t       strb;
  logic [PL_W-1:0] rpl;

  privChkCtrl #(.SEL_W(SEL_W), .PL_W(PL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .selector(selector), .strb(strb), .rpl(rpl)
  );

  privChkDatapath #(
    .SEL_W(SEL_W), .PL_W(PL_W), .VEC_W(VEC_W), .GP_VEC(GP_VEC), .REG_OUT(REG_OUT)
  ) uDp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strb(strb), .rpl(rpl),
    .curPl(curPl), .selector(selector), .tgtDpl(tgtDpl), .tgtIsCode(tgtIsCode),
    .tgtConforming(tgtConforming), .gateDpl(gateDpl), .gateIsCall(gateIsCall),
    .ioPl(ioPl), .rspValid(rspValid), .allow(allow), .fault(fault),
    .faultCode(faultCode), .faultSel(faultSel), .newPl(newPl), .effPl(effPl)
  );
endmodule

// File: tb/privCheckUnit_test.sv
`timescale 1ns/1ps
module privCheckUnit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = '0, curPl = '0, tgtDpl = '0, gateDpl = '0, ioPl = '0;
  logic [15:0] selector = '0;
  logic tgtIsCode = 1'b0, tgtConforming = 1'b0, gateIsCall = 1'b0;

  logic rspValid, allow, fault;
  logic [7:0] faultCode;
  logic [15:0] faultSel;
  logic [1:0] newPl, effPl;
  logic cValid, cAllow, cFault;
  logic [7:0] cCode;
  logic [15:0] cSel;
  logic [1:0] cNewPl, cEffPl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  privCheckUnit #(.REG_OUT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .curPl(curPl),
    .selector(selector), .tgtDpl(tgtDpl), .tgtIsCode(tgtIsCode),
    .tgtConforming(tgtConforming), .gateDpl(gateDpl), .gateIsCall(gateIsCall),
    .ioPl(ioPl), .rspValid(rspValid), .allow(allow), .fault(fault),
    .faultCode(faultCode), .faultSel(faultSel), .newPl(newPl), .effPl(effPl)
  );

  privCheckUnit #(.REG_OUT(1'b0)) uutComb (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .curPl(curPl),
    .selector(selector), .tgtDpl(tgtDpl), .tgtIsCode(tgtIsCode),
    .tgtConforming(tgtConforming), .gateDpl(gateDpl), .gateIsCall(gateIsCall),
    .ioPl(ioPl), .rspValid(cValid), .allow(cAllow), .fault(cFault),
    .faultCode(cCode), .faultSel(cSel), .newPl(cNewPl), .effPl(cEffPl)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic void model(
    input logic [1:0] k, input logic [1:0] cpl, input logic [15:0] sel,
    input logic [1:0] td, input logic tc, input logic tcf,
    input logic [1:0] gd, input logic gc, input logic [1:0] io,
    output logic eA, output logic [7:0] eC, output logic [15:0] eS,
    output logic [1:0] eN, output logic [1:0] eE);
    logic [1:0] r;
    logic isNull, ok;
    r = sel[1:0];
    isNull = (sel[15:3] == 13'd0) && (sel[2] == 1'b0);
    eE = (cpl >= r) ? cpl : r;
    ok = 1'b0;
    case (k)
      2'd0: ok = isNull || (td >= cpl && td >= r);
      2'd1: ok = !isNull && tc && (tcf ? (td <= cpl) : (td == cpl));
      2'd2: ok = !isNull && gc && tc && gd >= cpl && gd >= r && gd >= td && td <= cpl;
      default: ok = (cpl <= io);
    endcase
    eA = ok;
    eC = ok ? 8'd0 : 8'd13;
    eS = (ok || k == 2'd3) ? 16'd0 : sel;
    eN = (ok && k == 2'd2 && !tcf) ? td : cpl;
  endfunction

  task automatic doReq(input string tag, input logic [1:0] k, input logic [1:0] cpl,
                       input logic [15:0] sel, input logic [1:0] td, input logic tc,
                       input logic tcf, input logic [1:0] gd, input logic gc,
                       input logic [1:0] io);
    logic eA;
    logic [7:0] eC;
    logic [15:0] eS;
    logic [1:0] eN, eE;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; curPl = cpl; selector = sel; tgtDpl = td;
    tgtIsCode = tc; tgtConforming = tcf; gateDpl = gd; gateIsCall = gc; ioPl = io;
    model(k, cpl, sel, td, tc, tcf, gd, gc, io, eA, eC, eS, eN, eE);
    #1;
    cmp(tag, "comb allow", 32'(cAllow), 32'(eA));
    cmp(tag, "comb fault", 32'(cFault), 32'(!eA));
    cmp("R9", "comb faultCode", 32'(cCode), 32'(eC));
    cmp("R9", "comb faultSel", 32'(cSel), 32'(eS));
    cmp(tag, "comb newPl", 32'(cNewPl), 32'(eN));
    cmp("R2", "comb effPl", 32'(cEffPl), 32'(eE));
    @(posedge clk);
    #1;
    cmp("R11", "reg rspValid", 32'(rspValid), 32'd1);
    cmp(tag, "reg allow", 32'(allow), 32'(eA));
    cmp(tag, "reg fault", 32'(fault), 32'(!eA));
    cmp("R9", "reg faultCode", 32'(faultCode), 32'(eC));
    cmp("R9", "reg faultSel", 32'(faultSel), 32'(eS));
    cmp(tag, "reg newPl", 32'(newPl), 32'(eN));
    cmp("R2", "reg effPl", 32'(effPl), 32'(eE));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL R11 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R11", "reset rspValid", 32'(rspValid), 32'd0);
    cmp("R11", "reset allow", 32'(allow), 32'd0);
    cmp("R11", "reset fault", 32'(fault), 32'd0);
    cmp("R11", "idle comb allow", 32'(cAllow), 32'd0);
    cmp("R11", "idle comb fault", 32'(cFault), 32'd0);
    rstN = 1'b1;

    // R1: local-table index 0 is not null; global index 0 is
    doReq("R1", 2'd1, 2'd2, 16'h0006, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R8", 2'd1, 2'd2, 16'h0002, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R1", 2'd2, 2'd3, 16'h0008, 2'd0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd0);
    doReq("R8", 2'd2, 2'd3, 16'h0003, 2'd0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd0);
    // R3: null data load allowed even with a trusted descriptor level
    doReq("R3", 2'd0, 2'd3, 16'h0003, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R3", 2'd0, 2'd1, 16'h0012, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R3", 2'd0, 2'd1, 16'h0012, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
    // R4 / R5: non-conforming exact match, conforming more trusted
    doReq("R4", 2'd1, 2'd1, 16'h0020, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R5", 2'd1, 2'd1, 16'h0020, 2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0);
    doReq("R5", 2'd1, 2'd1, 16'h0020, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0);
    // R10: type mismatches
    doReq("R10", 2'd1, 2'd0, 16'h0020, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0);
    doReq("R10", 2'd2, 2'd3, 16'h0023, 2'd0, 1'b1, 1'b0, 2'd3, 1'b0, 2'd0);
    doReq("R10", 2'd2, 2'd3, 16'h0023, 2'd0, 1'b0, 1'b0, 2'd3, 1'b1, 2'd0);
    // R6: ring drop, conforming target keeps ring, gate RPL failure
    doReq("R6", 2'd2, 2'd3, 16'h0033, 2'd0, 1'b1, 1'b0, 2'd3, 1'b1, 2'd0);
    doReq("R6", 2'd2, 2'd3, 16'h0033, 2'd1, 1'b1, 1'b1, 2'd3, 1'b1, 2'd0);
    doReq("R6", 2'd2, 2'd1, 16'h0033, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, 2'd0);
    // R7: descriptor fields ignored for I/O requests
    doReq("R7", 2'd3, 2'd2, 16'hFFFF, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 2'd2);
    doReq("R7", 2'd3, 2'd3, 16'h0000, 2'd3, 1'b1, 1'b0, 2'd3, 1'b1, 2'd2);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] k;
      logic [15:0] sel;
      string tag;
      logic tcf;
      k = 2'($urandom);
      sel = 16'($urandom);
      if ($urandom % 8 == 0) sel = {13'd0, 1'b0, sel[1:0]};
      tcf = 1'($urandom);
      case (k)
        2'd0: tag = "R3";
        2'd1: tag = tcf ? "R5" : "R4";
        2'd2: tag = "R6";
        default: tag = "R7";
      endcase
      doReq(tag, k, 2'($urandom), sel, 2'($urandom), ($urandom % 4) != 0, tcf,
            2'($urandom), ($urandom % 4) != 0, 2'($urandom));
    end

    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    cmp("R11", "idle rspValid", 32'(rspValid), 32'd0);
    cmp("R11", "idle comb allow", 32'(cAllow), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule